// File: doc/BRIEF.md
# Posted Write Acceptance Controller

This block is the target-side front end of a bus bridge for posted memory writes. It watches a simplified parallel-bus target handshake. All signals are active high. When a write that the bridge forwards is seen, it claims the cycle and writes an address/command header into a posted-write FIFO. It then stores one data word into that FIFO on every clock on which the initiator is ready. It never waits for the far-side bus.

The block decides on which data phase to return a target disconnect. The decision uses the transaction type, the cache line size, a line-split control bit, the current DWORD address and the FIFO free count. When the FIFO cannot take a header plus one word, the block answers with a target retry. This also covers a second write that arrives back-to-back with no idle cycle.

The FIFO free count is the number of free entries in the cycle it is sampled. The FIFO itself and the far-side master are outside the block.

Top module: `pw_accept_ctrl`

## Requirements
- R1: Claim timing. For a cycle seen as an address phase (frame rising from idle), the block claims when three conditions hold: the decode hit is high, the command is 4'b0111 (memory write) or 4'b1111 (memory write with invalidate), and free is at least 2 in the following (decode) cycle. In that decode cycle it writes one header entry. devsel rises two cycles after the address phase, and trdy follows one cycle later.
- R2: FIFO word format. A header entry has fifo_hdr=1 and fifo_wdata={cmd, addr[31:2], 2'b00}. A data entry has fifo_hdr=0 and fifo_wdata={4'b0000, data}, written exactly on cycles where irdy and trdy are both high.
- R3: Wait states and normal end. trdy stays high while the initiator stalls, so no target wait state is inserted. A write whose initiator lowers frame before any limit is reached completes with no stop.
- R4: Memory write with the split bit at 0 disconnects on the data phase whose DWORD address has its low 10 bits all ones (the end of a 4 KB page).
- R5: Memory write with the split bit at 1 disconnects at the end of a cache line when the line size is 1, 2, 4, 8 or 16 DWORDs. With any other line size it falls back to the 4 KB page end.
- R6: Memory write with invalidate and a line size outside {1, 2, 4, 8, 16} disconnects at the 4 KB page end.
- R7: Memory write with invalidate and a line size of 1, 2, 4 or 8 disconnects at a line end only if free in that cycle is less than line size plus one. A 4 KB page end always disconnects.
- R8: Memory write with invalidate and a line size of 16 always disconnects on the last DWORD of each 16-DWORD aligned block.
- R9: The data phase accepted while free equals 1 carries stop together with trdy. No FIFO write occurs while free is 0.
- R10: If free is below 2 in the decode cycle of a claimable write, the block answers with a target retry: devsel and stop high, trdy low, and no FIFO write. This includes a write whose address phase immediately follows the last data phase of the previous write.
- R11: A command other than the two posted writes, or a cycle with the hit low, gets no devsel, no trdy and no FIFO write.
- R12: After a disconnect while frame is still high, devsel and stop stay high with trdy low, and no data is accepted, until frame falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_frame | input | 1 | Initiator frame, high while the transaction runs |
| bus_irdy | input | 1 | Initiator ready |
| bus_cmd | input | 4 | Command, valid in the address phase |
| bus_addr | input | ADDR_W | Byte address, valid in the address phase |
| bus_data | input | DATA_W | Write data for the current data phase |
| tgt_hit | input | 1 | Address decode result, valid in the address phase |
| line_dw | input | CLS_W | Cache line size in DWORDs |
| split_on_line | input | 1 | Memory write disconnect control: 1 selects line ends |
| fifo_free | input | FREE_W | Free FIFO entries this cycle |
| devsel | output | 1 | Device select (claim) |
| trdy | output | 1 | Target ready |
| stop | output | 1 | Target stop (disconnect or retry) |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_hdr | output | 1 | Current FIFO word is a transaction header |
| fifo_wdata | output | WORD_W | FIFO write word |

## Verification
The strobes and handshake outputs depend only on registered state and the free count, with one exception: fifo_we also follows irdy in the same cycle. So each data-phase result is due in the very cycle the initiator presents the word. The header is due one cycle after the address phase, devsel two cycles after, and trdy three cycles after. The bench drives inputs on the falling edge and samples the outputs a moment later, in the same cycle. It counts cycles from the address phase, so each result is compared at its exact due cycle. Disconnect placement is checked against counts of accepted words, worked out from the DWORD address, the line size and a free-count model that drops by one on every FIFO write.

// File: rtl/pw_accept_pkg.sv
package pw_accept_pkg;

  localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
  localparam logic [3:0] CMD_MEM_WR_INV = 4'b1111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_CLAIM,
    ST_DATA,
    ST_HOLD,
    ST_RETRY,
    ST_SKIP
  } tgt_state_t;

  function automatic logic is_posted_cmd(input logic [3:0] c);
    return (c == CMD_MEM_WR) || (c == CMD_MEM_WR_INV);
  endfunction

  // line sizes that define a usable aligned cache line
  function automatic logic line_size_legal(input logic [31:0] cls);
    return (cls == 32'd1) || (cls == 32'd2) || (cls == 32'd4) ||
           (cls == 32'd8) || (cls == 32'd16);
  endfunction

  // true when dw is the last DWORD of an aligned block of span (power of two)
  function automatic logic last_in_span(input logic [31:0] dw, input logic [31:0] span);
    return (dw & (span - 32'd1)) == (span - 32'd1);
  endfunction

  // free entries, counting the current word, leave room for one more full line
  function automatic logic room_for_next_line(input logic [31:0] free, input logic [31:0] cls);
    return free > cls;
  endfunction

endpackage

// File: rtl/pw_addr_track.sv
module pw_addr_track #(
  parameter int ADDR_W = 32,
  localparam int DW_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [3:0]        load_cmd,
  input  logic              load_hit,
  input  logic              step,
  output logic [DW_W-1:0]   cur_dw,
  output logic [DW_W-1:0]   start_dw,
  output logic [3:0]        cmd_q,
  output logic              hit_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_dw   <= '0;
      start_dw <= '0;
      cmd_q    <= '0;
      hit_q    <= 1'b0;
    end else if (load) begin
      cur_dw   <= load_addr[ADDR_W-1:2];
      start_dw <= load_addr[ADDR_W-1:2];
      cmd_q    <= load_cmd;
      hit_q    <= load_hit;
    end else if (step) begin
      cur_dw   <= cur_dw + 1'b1;
    end
  end

endmodule

// File: rtl/pw_disc_rules.sv
module pw_disc_rules
  import pw_accept_pkg::*;
#(
  parameter int DW_W    = 30,
  parameter int CLS_W   = 8,
  parameter int FREE_W  = 6,
  parameter int PAGE_DW = 1024,
  parameter int BIG_LINE = 16
) (
  input  logic [3:0]        cmd,
  input  logic [DW_W-1:0]   dw,
  input  logic [CLS_W-1:0]  cls,
  input  logic              split_on_line,
  input  logic [FREE_W-1:0] free,
  output logic              bound_stop,
  output logic              full_stop
);

  logic [31:0] dw32, cls32, free32;
  logic        cls_ok, page_end, line_end, room_ok;

  assign dw32   = 32'(dw);
  assign cls32  = 32'(cls);
  assign free32 = 32'(free);

  assign cls_ok   = line_size_legal(cls32);
  assign page_end = last_in_span(dw32, 32'(PAGE_DW));
  assign line_end = cls_ok && last_in_span(dw32, cls32);
  assign room_ok  = room_for_next_line(free32, cls32);

  always_comb begin
    bound_stop = page_end;
    if (cmd == CMD_MEM_WR_INV) begin
      if (!cls_ok)
        bound_stop = page_end;
      else if (cls32 == 32'(BIG_LINE))
        bound_stop = last_in_span(dw32, 32'(BIG_LINE));
      else
        bound_stop = page_end || (line_end && !room_ok);
    end else if (split_on_line && cls_ok) begin
      bound_stop = line_end || page_end;
    end
  end

  assign full_stop = (free32 <= 32'd1);

endmodule

// File: rtl/pw_tgt_fsm.sv
module pw_tgt_fsm
  import pw_accept_pkg::*;
#(
  parameter int FREE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame,
  input  logic              irdy,
  input  logic              claimable,
  input  logic [FREE_W-1:0] free,
  input  logic              bound_stop,
  input  logic              full_stop,
  output logic              devsel,
  output logic              trdy,
  output logic              stop,
  output logic              addr_load,
  output logic              hdr_we,
  output logic              xfer
);

  localparam logic [FREE_W-1:0] NEED_FREE = FREE_W'(2);

  tgt_state_t state_q, state_d;
  logic       free_zero;

  assign free_zero = (free == '0);

  always_comb begin
    state_d   = state_q;
    devsel    = 1'b0;
    trdy      = 1'b0;
    stop      = 1'b0;
    addr_load = 1'b0;
    hdr_we    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (frame) begin
          addr_load = 1'b1;
          state_d   = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (!claimable) begin
          state_d = ST_SKIP;
        end else if (free >= NEED_FREE) begin
          hdr_we  = 1'b1;
          state_d = ST_CLAIM;
        end else begin
          state_d = ST_RETRY;
        end
      end
      ST_CLAIM: begin
        devsel  = 1'b1;
        state_d = ST_DATA;
      end
      ST_DATA: begin
        devsel = 1'b1;
        trdy   = !free_zero;
        stop   = bound_stop || full_stop;
        if (irdy && trdy) begin
          if (!frame)     state_d = ST_IDLE;
          else if (stop)  state_d = ST_HOLD;
        end else if (!trdy) begin
          state_d = frame ? ST_HOLD : ST_IDLE;
        end
      end
      ST_HOLD, ST_RETRY: begin
        devsel = 1'b1;
        stop   = 1'b1;
        if (!frame) state_d = ST_IDLE;
      end
      ST_SKIP: begin
        if (!frame) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign xfer = irdy && trdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/pw_accept_ctrl.sv
module pw_accept_ctrl
  import pw_accept_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CLS_W      = 8,
  parameter int FIFO_DEPTH = 32,
  parameter int PAGE_BYTES = 4096,
  localparam int DW_W      = ADDR_W - 2,
  localparam int FREE_W    = $clog2(FIFO_DEPTH + 1),
  localparam int WORD_W    = 4 + ADDR_W,
  localparam int PAGE_DW   = PAGE_BYTES / 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_frame,
  input  logic              bus_irdy,
  input  logic [3:0]        bus_cmd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              tgt_hit,
  input  logic [CLS_W-1:0]  line_dw,
  input  logic              split_on_line,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              devsel,
  output logic              trdy,
  output logic              stop,
  output logic              fifo_we,
  output logic              fifo_hdr,
  output logic [WORD_W-1:0] fifo_wdata
);

  logic            load_w, hdr_w, xfer_w, bound_w, full_w, claim_w;
  logic [DW_W-1:0] cur_dw, start_dw;
  logic [3:0]      cmd_q;
  logic            hit_q;

  pw_addr_track #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_w),
    .load_addr (bus_addr),
    .load_cmd  (bus_cmd),
    .load_hit  (tgt_hit),
    .step      (xfer_w),
    .cur_dw    (cur_dw),
    .start_dw  (start_dw),
    .cmd_q     (cmd_q),
    .hit_q     (hit_q)
  );

  pw_disc_rules #(
    .DW_W    (DW_W),
    .CLS_W   (CLS_W),
    .FREE_W  (FREE_W),
    .PAGE_DW (PAGE_DW),
    .BIG_LINE(16)
  ) u_rules (
    .cmd          (cmd_q),
    .dw           (cur_dw),
    .cls          (line_dw),
    .split_on_line(split_on_line),
    .free         (fifo_free),
    .bound_stop   (bound_w),
    .full_stop    (full_w)
  );

  assign claim_w = hit_q && is_posted_cmd(cmd_q);

  pw_tgt_fsm #(.FREE_W(FREE_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame     (bus_frame),
    .irdy      (bus_irdy),
    .claimable (claim_w),
    .free      (fifo_free),
    .bound_stop(bound_w),
    .full_stop (full_w),
    .devsel    (devsel),
    .trdy      (trdy),
    .stop      (stop),
    .addr_load (load_w),
    .hdr_we    (hdr_w),
    .xfer      (xfer_w)
  );

  assign fifo_we    = hdr_w || xfer_w;
  assign fifo_hdr   = hdr_w;
  assign fifo_wdata = hdr_w ? {cmd_q, start_dw, 2'b00}
                            : {{(WORD_W - DATA_W){1'b0}}, bus_data};

endmodule

// File: rtl/pw_accept_chk.sv
module pw_accept_chk #(
  parameter int FREE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame,
  input logic              irdy,
  input logic              devsel,
  input logic              trdy,
  input logic              stop,
  input logic              fifo_we,
  input logic              fifo_hdr,
  input logic [FREE_W-1:0] fifo_free,
  input logic              xfer,
  input logic              bound_hit
);

  // R1: header is followed by a claim cycle without data
  assert_hdr_then_claim_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we && fifo_hdr) |=> (devsel && !trdy && !stop && !fifo_we));

  // R1: trdy comes one cycle after the bare claim
  assert_trdy_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (devsel && !trdy && !stop) |=> trdy);

  // R1: devsel rises two cycles after an address phase
  assert_devsel_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel) |-> $past(frame, 2));

  // R2: data words only on completed phases
  assert_data_on_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we && !fifo_hdr) |-> (irdy && trdy && devsel));

  // R9: never write into a full FIFO
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> (fifo_free != '0));

  // R12: after a disconnect with frame high, hold stop without trdy
  assert_hold_after_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && stop && frame) |=> (devsel && stop && !trdy));

  // R4..R8: a boundary hit on an accepted phase signals stop
  assert_bound_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && bound_hit) |-> stop);

endmodule

bind pw_accept_ctrl pw_accept_chk #(.FREE_W(FREE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame    (bus_frame),
  .irdy     (bus_irdy),
  .devsel   (devsel),
  .trdy     (trdy),
  .stop     (stop),
  .fifo_we  (fifo_we),
  .fifo_hdr (fifo_hdr),
  .fifo_free(fifo_free),
  .xfer     (xfer_w),
  .bound_hit(bound_w)
);

// File: tb/pw_accept_ctrl_tb.sv
module pw_accept_ctrl_tb;

  localparam int FREE_W = 6;
  localparam logic [3:0] MW  = 4'b0111;
  localparam logic [3:0] MWI = 4'b1111;
  localparam logic [3:0] IOW = 4'b0011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame = 1'b0, irdy = 1'b0, hit = 1'b1, split = 1'b0;
  logic [3:0]  cmd = '0;
  logic [31:0] addr = '0, data = '0;
  logic [7:0]  cls = 8'd8;
  logic [FREE_W-1:0] free;
  logic        devsel, trdy, stop, fifo_we, fifo_hdr;
  logic [35:0] fifo_wdata;

  int cap = 32, used = 0;
  logic clr = 1'b0;
  int total = 0, bad = 0, wd = 0;

  int r_got, r_dev_at, r_trdy_at, r_last, r_data_bad, r_hold_bad, r_stall_bad, r_stray;
  bit r_dis, r_rty, r_hdr_seen, r_hdr_ok;

  always #4 clk = ~clk;

  assign free = (cap > used) ? FREE_W'(cap - used) : '0;

  always @(posedge clk) begin
    if (clr) used <= 0;
    else if (fifo_we) used <= used + 1;
  end

  pw_accept_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_frame(frame), .bus_irdy(irdy), .bus_cmd(cmd),
    .bus_addr(addr), .bus_data(data), .tgt_hit(hit), .line_dw(cls),
    .split_on_line(split), .fifo_free(free), .devsel(devsel), .trdy(trdy),
    .stop(stop), .fifo_we(fifo_we), .fifo_hdr(fifo_hdr), .fifo_wdata(fifo_wdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_fifo(input int c);
    @(negedge clk); frame = 1'b0; irdy = 1'b0; cap = c; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // one initiator write; counts cycles from the address phase (cycle 0)
  task automatic wr(input logic [3:0] c, input logic [31:0] a, input int n, input int stall);
    int left = n, cyc = 0;
    bit stp = 0, fin = 0, rel = 0;
    r_got = 0; r_dev_at = -1; r_trdy_at = -1; r_last = -1; r_data_bad = 0;
    r_hold_bad = 0; r_stall_bad = 0; r_stray = 0;
    r_dis = 0; r_rty = 0; r_hdr_seen = 0; r_hdr_ok = 0;
    @(negedge clk); frame = 1'b1; cmd = c; addr = a; irdy = 1'b0;
    #1; if (devsel || fifo_we) r_stray++;
    while (!fin) begin
      @(negedge clk); cyc++;
      rel = stp || (cyc >= 6 && r_dev_at < 0);
      if (rel) begin
        frame = 1'b0; irdy = 1'b0;
      end else begin
        irdy  = !(cyc == stall && left > 1);
        frame = (left != 1);
        data  = 32'hC0DE_0000 + 32'(r_got);
      end
      #1;
      if (rel) begin
        if (stp && !(devsel && stop && !trdy)) r_hold_bad++;
        if (fifo_we) r_stray++;
        fin = 1;
      end else begin
        if (devsel && r_dev_at < 0) r_dev_at = cyc;
        if (trdy && r_trdy_at < 0) r_trdy_at = cyc;
        if (fifo_we && fifo_hdr) begin
          r_hdr_seen = 1;
          r_hdr_ok = (cyc == 1) && (fifo_wdata == {c, a[31:2], 2'b00});
        end
        if (fifo_we && !fifo_hdr && !devsel) r_stray++;
        if (!irdy && cyc == stall && (!trdy || fifo_we)) r_stall_bad++;
        if (irdy && trdy) begin
          if (!(fifo_we && !fifo_hdr && fifo_wdata == {4'h0, data})) r_data_bad++;
          r_got++; left--; r_last = cyc;
          if (!frame && !stop) fin = 1;
        end
        if (devsel && stop) begin
          if (trdy || r_trdy_at >= 0) r_dis = 1; else r_rty = 1;
          if (frame) stp = 1; else fin = 1;
        end
      end
    end
  endtask

  task automatic t_reset;
    #1;
    chk("R1 reset devsel", int'(devsel), 0);
    chk("R1 reset trdy/stop", int'(trdy || stop), 0);
    chk("R2 reset fifo_we", int'(fifo_we), 0);
  endtask

  task automatic t_basic;
    set_fifo(32); split = 1'b0;
    wr(MW, 32'h0000_0100, 4, -1);
    chk("R1 devsel cycle", r_dev_at, 2);
    chk("R1 trdy cycle", r_trdy_at, 3);
    chk("R1 header", int'(r_hdr_seen && r_hdr_ok), 1);
    chk("R2 data words", r_data_bad, 0);
    chk("R3 count", r_got, 4);
    chk("R3 no stop", int'(r_dis || r_rty), 0);
    chk("R3 last phase cycle", r_last, 6);
  endtask

  task automatic t_stall;
    set_fifo(32);
    wr(MW, 32'h0000_0200, 5, 4);
    chk("R3 stall keeps trdy", r_stall_bad, 0);
    chk("R3 stall count", r_got, 5);
    chk("R3 stall last cycle", r_last, 8);
    chk("R2 stall data", r_data_bad, 0);
  endtask

  task automatic t_page_mw;
    set_fifo(32); split = 1'b0; cls = 8'd8;
    wr(MW, 32'h0000_0FF4, 8, -1);
    chk("R4 page count", r_got, 3);
    chk("R4 disconnect", int'(r_dis), 1);
    chk("R12 hold", r_hold_bad, 0);
  endtask

  task automatic t_line_mw;
    set_fifo(32); split = 1'b1; cls = 8'd8;
    wr(MW, 32'h0000_0014, 10, -1);
    chk("R5 line count", r_got, 3);
    chk("R5 disconnect", int'(r_dis), 1);
    chk("R12 hold line", r_hold_bad, 0);
    set_fifo(32); cls = 8'd6;
    wr(MW, 32'h0000_0014, 10, -1);
    chk("R5 odd line ignored", r_got, 10);
    chk("R5 odd line no stop", int'(r_dis), 0);
    split = 1'b0;
  endtask

  task automatic t_mwi;
    set_fifo(32); cls = 8'd16;
    wr(MWI, 32'h0000_000C, 20, -1);
    chk("R8 block16 count", r_got, 13);
    chk("R8 disconnect", int'(r_dis), 1);
    set_fifo(32); cls = 8'd4;
    wr(MWI, 32'h0000_0000, 10, -1);
    chk("R7 room continue", r_got, 10);
    chk("R7 room no stop", int'(r_dis), 0);
    set_fifo(12); cls = 8'd8;
    wr(MWI, 32'h0000_0000, 12, -1);
    chk("R7 tight count", r_got, 8);
    chk("R7 tight disconnect", int'(r_dis), 1);
    set_fifo(32); cls = 8'd12;
    wr(MWI, 32'h0000_0FF0, 8, -1);
    chk("R6 odd line page count", r_got, 4);
    chk("R6 disconnect", int'(r_dis), 1);
  endtask

  task automatic t_full;
    set_fifo(5); cls = 8'd8;
    wr(MW, 32'h0000_0000, 10, -1);
    chk("R9 full count", r_got, 4);
    chk("R9 full disconnect", int'(r_dis), 1);
  endtask

  task automatic t_retry;
    set_fifo(3);
    wr(MW, 32'h0000_0040, 1, -1);
    chk("R10 first write ok", r_got, 1);
    wr(MW, 32'h0000_0080, 1, -1);
    chk("R10 retry seen", int'(r_rty), 1);
    chk("R10 no data", r_got, 0);
    chk("R10 no header", int'(r_hdr_seen), 0);
    chk("R10 no stray", r_stray, 0);
  endtask

  task automatic t_ignore;
    set_fifo(32);
    wr(IOW, 32'h0000_0300, 1, -1);
    chk("R11 io devsel", r_dev_at, -1);
    chk("R11 io no write", int'(r_hdr_seen) + r_stray + r_got, 0);
    set_fifo(32); hit = 1'b0;
    wr(MW, 32'h0000_0300, 1, -1);
    chk("R11 miss devsel", r_dev_at, -1);
    chk("R11 miss no write", int'(r_hdr_seen) + r_stray + r_got, 0);
    hit = 1'b1;
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_basic;
    t_stall;
    t_page_mw;
    t_line_mw;
    t_mwi;
    t_full;
    t_retry;
    t_ignore;
    set_fifo(32);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule